// File: doc/BRIEF.md
# Burst Latency Timer

This block lives inside a bus master that can issue long bursts. It bounds how long a single burst may keep the bus by counting clocks from the moment the slave accepts the burst's address. When the count passes a programmed limit, the block raises a request to end the burst. The master's burst engine acts on that request.

The limit and a termination policy are held in a small configuration register that is written through a side configuration port. The policy sets when the request fires once the limit is passed. It may fire at once. It may wait until any other master asks for the bus. It may wait until another master asks at a strictly higher priority than this master's own. The competing requests and their priorities arrive as one flag and one priority field per other master.

Top module: `burst_latency_timer`

## Requirements
- R1: After reset, `lat_count` is 0 and `term_req` is 0. The stored limit is 0 and the stored policy is 0.
- R2: While `cfg_we` is high at a clock edge, `cfg_limit` and `cfg_policy` are stored. While `cfg_we` is low, changes on those inputs have no effect on timing.
- R3: At the first clock edge where `addr_ack` is high with `burst_active` high, `lat_count` becomes 0 and counting starts. After that it rises by exactly 1 at every clock edge, so it reads k after the k-th edge that follows the acknowledge edge.
- R4: `addr_ack` is ignored while `burst_active` is low, and also while a count is already running. It neither starts nor restarts the counter.
- R5: The counter saturates at 2^CNT_W-1 (255 by default) and does not wrap.
- R6: At any clock edge where `burst_active` is low, the counter stops and `lat_count` becomes 0. `term_req` becomes 0 at that same edge, and this holds even in a cycle where the termination would otherwise have fired.
- R7: The count is over the limit when `lat_count` > limit. With policy 0 (encoding 2'b00), `term_req` rises at the clock edge that follows the first cycle in which the count is over the limit. With a limit L, it therefore reads 1 first after the (L+2)-th edge that follows the acknowledge edge.
- R8: With policy 1 (2'b01), `term_req` rises at the first clock edge that follows a cycle in which the count is over the limit and at least one `other_req` bit is high.
- R9: With policy 2 (2'b10), `term_req` rises only after a cycle in which the count is over the limit and some `other_req[i]` is high with `other_prio[i]` (bits i*PRIO_W upward) strictly greater than `own_prio`. A request at an equal or lower priority has no effect.
- R10: Policy 3 (2'b11) behaves exactly as policy 0.
- R11: A stored limit of 0 disables termination: `term_req` stays 0 under every policy and every request pattern.
- R12: Once `term_req` is high, it stays high for as long as `burst_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_limit | input | CNT_W | Latency limit to store |
| cfg_policy | input | 2 | Termination policy to store |
| burst_active | input | 1 | High while this master's burst is in progress |
| addr_ack | input | 1 | Slave acknowledge of the burst address |
| own_prio | input | PRIO_W | Priority of this master's current request |
| other_req | input | N_OTHER | Bus request from each other master |
| other_prio | input | N_OTHER*PRIO_W | Request priority of each other master, packed |
| term_req | output | 1 | Request to end the current burst |
| lat_count | output | CNT_W | Current latency count |

## Verification
Two things can land on the same clock edge. One is the end of the burst. The other is the moment the terminate request would rise, either because the count has just passed the limit or because a competing request has just appeared. The bench programs a small limit and lowers `burst_active` exactly on the edge where policy 0 would raise `term_req`. Just after that edge it requires `term_req` to be 0 and the count to be 0. A second pairing is a competing request that arrives in the same cycle the count crosses the limit. The table rows with a request present from the start check this: the request must rise at the limit-driven cycle, neither earlier nor later.

// File: rtl/blt_pkg.sv
package blt_pkg;

    typedef enum logic [1:0] {
        BLT_POL_NOW    = 2'b00,
        BLT_POL_ANY    = 2'b01,
        BLT_POL_HIGHER = 2'b10,
        BLT_POL_RSVD   = 2'b11
    } blt_policy_e;

endpackage

// File: rtl/blt_cfg.sv
module blt_cfg
    import blt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic [1:0]       cfg_policy,
    output logic [CNT_W-1:0] limit,
    output blt_policy_e      policy
);

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        blt_policy_e      policy;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.limit  = cfg_limit;
            st_d.policy = blt_policy_e'(cfg_policy);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.limit  <= '0;
            st_q.policy <= BLT_POL_NOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign limit  = st_q.limit;
    assign policy = st_q.policy;

    // R2: without a write strobe the stored settings hold
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q));

endmodule

// File: rtl/blt_counter.sv
module blt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_active,
    input  logic             addr_ack,
    output logic             running,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!burst_active) begin
            st_d.running = 1'b0;
            st_d.count   = '0;
        end else if (!st_q.running) begin
            if (addr_ack) begin
                st_d.running = 1'b1;
                st_d.count   = '0;
            end
        end else if (st_q.count != CNT_MAX) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.running <= 1'b0;
            st_q.count   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.running;
    assign count   = st_q.count;

    // R3: one step per clock while a burst is timed
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.running && burst_active && st_q.count != CNT_MAX
        |=> st_q.count == $past(st_q.count) + 1'b1);

    // R5: no wrap at the top
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.running && burst_active && st_q.count == CNT_MAX
        |=> st_q.count == CNT_MAX);

    // R6: end of burst clears and stops
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |=> !st_q.running && st_q.count == '0);

    // R4: idle counter stays at zero without a valid acknowledge
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.running && !(addr_ack && burst_active) |=> !st_q.running && st_q.count == '0);

endmodule

// File: rtl/blt_compete.sv
module blt_compete #(
    parameter int N_OTHER = 3,
    parameter int PRIO_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PRIO_W-1:0]         own_prio,
    input  logic [N_OTHER-1:0]        other_req,
    input  logic [N_OTHER*PRIO_W-1:0] other_prio,
    output logic                      any_req,
    output logic                      any_higher
);

    logic [N_OTHER-1:0] higher;

    for (genvar i = 0; i < N_OTHER; i++) begin : g_cmp
        always_comb begin
            higher[i] = other_req[i] && (other_prio[i*PRIO_W +: PRIO_W] > own_prio);
        end
    end

    always_comb begin
        any_req    = |other_req;
        any_higher = |higher;
    end

    // R9: a higher-priority competitor is always also a competitor
    a_r9_subset: assert property (@(posedge clk) disable iff (!rst_n)
        any_higher |-> any_req);

endmodule

// File: rtl/blt_terminate.sv
module blt_terminate
    import blt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_active,
    input  logic             running,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    input  blt_policy_e      policy,
    input  logic             any_req,
    input  logic             any_higher,
    output logic             term_req
);

    typedef struct packed {
        logic term;
    } term_state_t;

    term_state_t st_d, st_q;
    logic        expired;
    logic        allow;

    always_comb begin
        expired = running && (limit != '0) && (count > limit);
        unique case (policy)
            BLT_POL_ANY:    allow = any_req;
            BLT_POL_HIGHER: allow = any_higher;
            default:        allow = 1'b1;
        endcase
        st_d = st_q;
        if (!burst_active) begin
            st_d.term = 1'b0;
        end else if (expired && allow) begin
            st_d.term = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.term <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign term_req = st_q.term;

    // R12: sticky while the burst lasts
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.term && burst_active |=> st_q.term);

    // R11: a zero limit never lets the request rise
    a_r11_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        limit == '0 && !st_q.term |=> !st_q.term);

    // R9: priority policy waits for a strictly higher competitor
    a_r9_wait: assert property (@(posedge clk) disable iff (!rst_n)
        policy == BLT_POL_HIGHER && !any_higher && !st_q.term |=> !st_q.term);

    // R8: any-request policy waits for a competitor
    a_r8_wait: assert property (@(posedge clk) disable iff (!rst_n)
        policy == BLT_POL_ANY && !any_req && !st_q.term |=> !st_q.term);

    // R6: request drops with the burst
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |=> !st_q.term);

endmodule

// File: rtl/burst_latency_timer.sv
module burst_latency_timer
    import blt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRIO_W  = 2,
    parameter int N_OTHER = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CNT_W-1:0]          cfg_limit,
    input  logic [1:0]                cfg_policy,
    input  logic                      burst_active,
    input  logic                      addr_ack,
    input  logic [PRIO_W-1:0]         own_prio,
    input  logic [N_OTHER-1:0]        other_req,
    input  logic [N_OTHER*PRIO_W-1:0] other_prio,
    output logic                      term_req,
    output logic [CNT_W-1:0]          lat_count
);

    logic [CNT_W-1:0] limit;
    blt_policy_e      policy;
    logic             running;
    logic [CNT_W-1:0] count;
    logic             any_req;
    logic             any_higher;

    blt_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_limit  (cfg_limit),
        .cfg_policy (cfg_policy),
        .limit      (limit),
        .policy     (policy)
    );

    blt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_active (burst_active),
        .addr_ack     (addr_ack),
        .running      (running),
        .count        (count)
    );

    blt_compete #(.N_OTHER(N_OTHER), .PRIO_W(PRIO_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_prio   (own_prio),
        .other_req  (other_req),
        .other_prio (other_prio),
        .any_req    (any_req),
        .any_higher (any_higher)
    );

    blt_terminate #(.CNT_W(CNT_W)) u_term (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_active (burst_active),
        .running      (running),
        .count        (count),
        .limit        (limit),
        .policy       (policy),
        .any_req      (any_req),
        .any_higher   (any_higher),
        .term_req     (term_req)
    );

    assign lat_count = count;

    // R7: terminate only while a count is over a nonzero limit or already latched
    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !term_req |=> !term_req || $past(running && limit != '0 && count > limit));

endmodule

// File: tb/sim_burst_latency_timer.sv
module sim_burst_latency_timer;

    localparam int NEVER = 63;
    localparam int NVEC  = 12;

    typedef struct packed {
        logic [1:0] pol;
        logic [7:0] lim;
        logic [1:0] own;
        logic [2:0] oreq;
        logic [5:0] oprio;
        logic [5:0] req_at;
        logic [5:0] exp_k;
    } vec_t;

    // exp_k: index of the first edge after the acknowledge edge at which term_req reads 1
    localparam vec_t TAB [NVEC] = '{
        {2'd0, 8'd3,  2'd1, 3'b000, 6'b000000, 6'd0,  6'd5},   // R7
        {2'd0, 8'd10, 2'd1, 3'b000, 6'b000000, 6'd0,  6'd12},  // R7
        {2'd1, 8'd3,  2'd1, 3'b001, 6'b000000, 6'd10, 6'd11},  // R8 late request
        {2'd1, 8'd5,  2'd1, 3'b000, 6'b000000, 6'd0,  6'd63},  // R8 no request
        {2'd1, 8'd6,  2'd1, 3'b100, 6'b000000, 6'd2,  6'd8},   // R8 early request
        {2'd2, 8'd3,  2'd1, 3'b010, 6'b000100, 6'd0,  6'd63},  // R9 equal prio
        {2'd2, 8'd3,  2'd1, 3'b010, 6'b001000, 6'd0,  6'd5},   // R9 higher prio
        {2'd2, 8'd4,  2'd2, 3'b101, 6'b110001, 6'd15, 6'd16},  // R9 mixed
        {2'd2, 8'd2,  2'd3, 3'b111, 6'b111111, 6'd0,  6'd63},  // R9 none higher
        {2'd3, 8'd7,  2'd1, 3'b000, 6'b000000, 6'd0,  6'd9},   // R10
        {2'd0, 8'd0,  2'd1, 3'b000, 6'b000000, 6'd0,  6'd63},  // R11
        {2'd1, 8'd0,  2'd0, 3'b111, 6'b111111, 6'd0,  6'd63}   // R11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_limit = '0;
    logic [1:0] cfg_policy = '0;
    logic       burst_active = 1'b0;
    logic       addr_ack = 1'b0;
    logic [1:0] own_prio = '0;
    logic [2:0] other_req = '0;
    logic [5:0] other_prio = '0;
    logic       term_req;
    logic [7:0] lat_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_latency_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_limit    (cfg_limit),
        .cfg_policy   (cfg_policy),
        .burst_active (burst_active),
        .addr_ack     (addr_ack),
        .own_prio     (own_prio),
        .other_req    (other_req),
        .other_prio   (other_prio),
        .term_req     (term_req),
        .lat_count    (lat_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] pol, input logic [7:0] lim);
        cfg_we = 1'b1; cfg_policy = pol; cfg_limit = lim;
        tick();
        cfg_we = 1'b0;
    endtask

    // raise burst and acknowledge; returns after the acknowledge edge (k = 0)
    task automatic start_burst();
        burst_active = 1'b1; addr_ack = 1'b1;
        tick();
        addr_ack = 1'b0;
    endtask

    task automatic end_burst();
        burst_active = 1'b0; other_req = '0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R1: reset state
        chk("R1 count", int'(lat_count), 0);
        chk("R1 term", int'(term_req), 0);
        rst_n = 1'b1;
        tick();
        // R1: stored limit is 0, so a burst under policy 0 never terminates
        start_burst();
        repeat (6) tick();
        chk("R1 limit zero", int'(term_req), 0);
        end_burst();

        for (int v = 0; v < NVEC; v++) begin
            int first;
            first = NEVER;
            own_prio = TAB[v].own;
            other_prio = TAB[v].oprio;
            cfg_write(TAB[v].pol, TAB[v].lim);
            start_burst();
            chk("R3 count at ack", int'(lat_count), 0);
            for (int k = 1; k <= 40; k++) begin
                other_req = (k - 1 >= int'(TAB[v].req_at)) ? TAB[v].oreq : 3'b000;
                tick();
                if (k == 3) chk("R3 count step", int'(lat_count), 3);
                if (term_req && first == NEVER) first = k;
            end
            chk($sformatf("R7/R8/R9/R10/R11 vec %0d first term", v), first, int'(TAB[v].exp_k));
            if (int'(TAB[v].exp_k) != NEVER) chk("R12 held", int'(term_req), 1);
            end_burst();
            chk("R6 term cleared", int'(term_req), 0);
            chk("R6 count cleared", int'(lat_count), 0);
        end

        // R4: acknowledge without an active burst is ignored
        other_req = '0;
        addr_ack = 1'b1;
        repeat (3) tick();
        addr_ack = 1'b0;
        chk("R4 ack idle", int'(lat_count), 0);
        // R4: a second acknowledge while counting does not restart
        start_burst();
        repeat (5) tick();
        addr_ack = 1'b1;
        tick();
        addr_ack = 1'b0;
        repeat (2) tick();
        chk("R4 second ack", int'(lat_count), 8);
        end_burst();

        // R5: saturation (limit 0 so no termination either)
        cfg_write(2'd0, 8'd0);
        start_burst();
        repeat (260) tick();
        chk("R5 saturate", int'(lat_count), 255);
        chk("R11 saturated no term", int'(term_req), 0);
        end_burst();

        // R2: inputs changed without the strobe have no effect
        cfg_write(2'd0, 8'd3);
        cfg_limit = 8'd20; cfg_policy = 2'd1;
        start_burst();
        repeat (4) tick();
        chk("R2 before", int'(term_req), 0);
        tick();
        chk("R2 held cfg", int'(term_req), 1);
        end_burst();
        cfg_limit = 8'd0; cfg_policy = 2'd0;

        // R6: burst ends on the very edge where the request would rise (k = 5)
        start_burst();
        repeat (4) tick();
        chk("R6 pre", int'(term_req), 0);
        burst_active = 1'b0;
        tick();
        chk("R6 collide term", int'(term_req), 0);
        chk("R6 collide count", int'(lat_count), 0);
        tick();
        chk("R6 stays low", int'(term_req), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule